// File: doc/BRIEF.md
# Multi-Core Shared Interrupt Router

This block collects a parameterised set of level-sensitive interrupt sources and steers each one to a single output line. Each output line is identified by a processor core and an interrupt pin on that core. Every source carries four pieces of state: an enable bit, a pending bit, a pin assignment and a core assignment. The output for a given core and pin is driven when at least one source routed to that pair is both pending and enabled. Each core also has a local interrupt input, such as a timer compare event. That input is folded into one pin of the same core through a small per-core route register.

Software configures the router over a simple word-addressed register bus. Reads return data one cycle after the request. Enables are changed through separate write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed. A core assignment is written as a one-hot mask and kept internally as an index. A trigger register lets software raise or drop the pending bit of any source.

Top module: `irq_router`

## Requirements
- R1: After reset every output is low, all enable and pending bits read 0, every pin map reads 32'h8000_0000 (route flag set, pin 0), every core map reads 0 (unmapped), and every local route reads 32'h8000_0000 (local input enabled onto pin 0).
- R2: A change on `srcIn[s]` copies its new level into the pending bit of source s at the next clock edge. Outputs are registered, so they follow one cycle after any change of state.
- R3: Writing the trigger register (word 0x001) sets the pending bit of source `wrData[30:0]` to `wrData[31]`. A source number at or above `NUM_SRC` is ignored.
- R4: Writing word 0x020+k sets the enable of source 32k+j for every 1 in bit j. Writing word 0x028+k clears it in the same way. A 0 bit leaves the enable unchanged. Word 0x018+k reads the enables back.
- R5: Word 0x010+k reads the pending bits, with bit j holding source 32k+j. Words and bits beyond `NUM_SRC` read 0.
- R6: The pin map of source s is at word 0x100+s: bit 31 is the route flag and bits 5:0 are the pin. A write whose pin is not below `NUM_PIN` is discarded entirely.
- R7: The core map of source s is at word 0x200+s. A write keeps the index of the lowest set bit, and writing 0 unmaps the source. A write whose lowest set bit is not below `NUM_CORE` is rejected. A read returns the one-hot mask of the stored index, or 0 when unmapped.
- R8: Output `irqOut[c*NUM_PIN+p]` is the OR, over all sources mapped to core c and pin p, of pending AND enabled. A pending source that is disabled or unmapped drives nothing, and it takes effect as soon as it is enabled.
- R9: The local route of core c is at word 0x030+c: bit 31 enables it and bits 5:0 select the pin. When the route is enabled, `localIrq[c]` is ORed into that core's selected pin. A write whose pin is out of range is discarded.
- R10: Word 0x000 reads configuration: bits 23:16 = `NUM_SRC`/8-1, bits 15:8 = `NUM_PIN`, bits 7:0 = `NUM_CORE`.
- R11: `rdData` is updated the cycle after `rdEn` and holds its value otherwise. Reads of unimplemented words return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and router clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 10 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| srcIn | input | NUM_SRC | Level-sensitive interrupt sources |
| localIrq | input | NUM_CORE | Per-core local interrupt inputs |
| irqOut | output | NUM_CORE*NUM_PIN | Routed interrupt lines, index core*NUM_PIN+pin |

## Verification
The bench targets the following corner cases:
- **Out-of-range trigger.** Source number 300 shares its low byte with source 44. A decoder that truncates the number would wrongly set pending bit 44.
- **Core mask with several bits set.** A design that failed to pick the lowest bit would read back a different mask. A design that let an index of 2 through on a two-core build would lose the existing route.
- **Disabled pending source.** The pending bit must show in the pending view, but the output must stay low until the source is enabled.
- **Two sources on one pin.** Dropping one of them must keep the line high.
- **Discarded writes.** Writes carrying an out-of-range pin to a pin map or a local route must leave the old value, including the flag bit. A design that stored the flag alone would fail here.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  // word addresses of register groups
  localparam int A_CFG   = 'h000;
  localparam int A_TRIG  = 'h001;
  localparam int A_PEND  = 'h010;
  localparam int A_EN    = 'h018;
  localparam int A_SET   = 'h020;
  localparam int A_CLR   = 'h028;
  localparam int A_LOCAL = 'h030;
  localparam int A_PIN   = 'h100;
  localparam int A_CORE  = 'h200;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CFG, RD_PEND, RD_EN, RD_PIN, RD_CORE, RD_LOCAL
  } rdSel_e;

  typedef struct packed {
    logic        trig;
    logic        setEn;
    logic        clrEn;
    logic        pinMap;
    logic        coreMap;
    logic        localRt;
    logic        rdStb;
    rdSel_e      rdSel;
    logic [7:0]  idx;
    logic [4:0]  coreIdx;
    logic        coreNone;
    logic [31:0] data;
  } strobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           stb
);
  localparam int WORDS = (NUM_SRC + 31) / 32;

  int         a;
  logic [4:0] lowBit;
  logic       pinOk;
  logic       coreOk;
  logic       srcOk;

  // index of the lowest set bit of the write data
  always_comb begin
    lowBit = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (wrData[b]) lowBit = 5'(b);
    end
  end

  assign pinOk  = int'(wrData[5:0]) < NUM_PIN;
  assign coreOk = (wrData == '0) || (int'(lowBit) < NUM_CORE);
  assign srcOk  = {1'b0, wrData[30:0]} < DATA_W'(NUM_SRC);

  always_comb begin
    a            = int'(addr);
    stb          = '0;
    stb.rdSel    = RD_ZERO;
    stb.rdStb    = rdEn;
    stb.data     = wrData;
    stb.coreIdx  = lowBit;
    stb.coreNone = (wrData == '0);
    if (a == A_CFG) begin
      stb.rdSel = RD_CFG;
    end else if (a == A_TRIG) begin
      stb.trig = wrEn && srcOk;
      stb.idx  = wrData[7:0];
    end else if (a >= A_PEND && a < A_PEND + WORDS) begin
      stb.rdSel = RD_PEND;
      stb.idx   = 8'(a - A_PEND);
    end else if (a >= A_EN && a < A_EN + WORDS) begin
      stb.rdSel = RD_EN;
      stb.idx   = 8'(a - A_EN);
    end else if (a >= A_SET && a < A_SET + WORDS) begin
      stb.setEn = wrEn;
      stb.idx   = 8'(a - A_SET);
    end else if (a >= A_CLR && a < A_CLR + WORDS) begin
      stb.clrEn = wrEn;
      stb.idx   = 8'(a - A_CLR);
    end else if (a >= A_LOCAL && a < A_LOCAL + NUM_CORE) begin
      stb.rdSel   = RD_LOCAL;
      stb.localRt = wrEn && pinOk;
      stb.idx     = 8'(a - A_LOCAL);
    end else if (a >= A_PIN && a < A_PIN + NUM_SRC) begin
      stb.rdSel  = RD_PIN;
      stb.pinMap = wrEn && pinOk;
      stb.idx    = 8'(a - A_PIN);
    end else if (a >= A_CORE && a < A_CORE + NUM_SRC) begin
      stb.rdSel   = RD_CORE;
      stb.coreMap = wrEn && coreOk;
      stb.idx     = 8'(a - A_CORE);
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [NUM_SRC-1:0]           srcIn,
  input  logic [NUM_CORE-1:0]          localIrq,
  output logic [NUM_CORE*NUM_PIN-1:0]  irqOut,
  output logic [DATA_W-1:0]            rdData
);
  localparam int PIN_W  = (NUM_PIN  > 1) ? $clog2(NUM_PIN)  : 1;
  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam int NOUT   = NUM_CORE * NUM_PIN;

  logic [NUM_SRC-1:0]  pendQ, enQ, srcLastQ, flagQ, mappedQ;
  logic [PIN_W-1:0]    pinQ    [NUM_SRC];
  logic [CORE_W-1:0]   coreQ   [NUM_SRC];
  logic [NUM_CORE-1:0] locEnQ;
  logic [PIN_W-1:0]    locPinQ [NUM_CORE];
  logic [NOUT-1:0]     hit;
  logic [DATA_W-1:0]   rdNext;

  // per-source state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      enQ      <= '0;
      srcLastQ <= '0;
      flagQ    <= '1;
      mappedQ  <= '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        pinQ[s]  <= '0;
        coreQ[s] <= '0;
      end
    end else begin
      srcLastQ <= srcIn;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (srcIn[s] != srcLastQ[s]) begin
          pendQ[s] <= srcIn[s];
        end else if (stb.trig && stb.idx == 8'(s)) begin
          pendQ[s] <= stb.data[31];
        end
        if (stb.setEn && stb.idx == 8'(s / 32) && stb.data[s % 32]) begin
          enQ[s] <= 1'b1;
        end else if (stb.clrEn && stb.idx == 8'(s / 32) && stb.data[s % 32]) begin
          enQ[s] <= 1'b0;
        end
        if (stb.pinMap && stb.idx == 8'(s)) begin
          pinQ[s]  <= PIN_W'(stb.data[5:0]);
          flagQ[s] <= stb.data[31];
        end
        if (stb.coreMap && stb.idx == 8'(s)) begin
          mappedQ[s] <= !stb.coreNone;
          coreQ[s]   <= CORE_W'(stb.coreIdx);
        end
      end
    end
  end

  // per-core local route
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locEnQ <= '1;
      for (int c = 0; c < NUM_CORE; c++) locPinQ[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CORE; c++) begin
        if (stb.localRt && stb.idx == 8'(c)) begin
          locEnQ[c]  <= stb.data[31];
          locPinQ[c] <= PIN_W'(stb.data[5:0]);
        end
      end
    end
  end

  // OR reduction onto each core/pin line
  always_comb begin
    hit = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int p = 0; p < NUM_PIN; p++) begin
        if (localIrq[c] && locEnQ[c] && locPinQ[c] == PIN_W'(p)) begin
          hit[c*NUM_PIN+p] = 1'b1;
        end
        for (int s = 0; s < NUM_SRC; s++) begin
          if (pendQ[s] && enQ[s] && mappedQ[s] &&
              coreQ[s] == CORE_W'(c) && pinQ[s] == PIN_W'(p)) begin
            hit[c*NUM_PIN+p] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= hit;
  end

  // read multiplexer
  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      RD_CFG: rdNext = {8'h00, 8'(NUM_SRC / 8 - 1), 8'(NUM_PIN), 8'(NUM_CORE)};
      RD_PEND: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (stb.idx == 8'(s / 32)) rdNext[s % 32] = pendQ[s];
      end
      RD_EN: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (stb.idx == 8'(s / 32)) rdNext[s % 32] = enQ[s];
      end
      RD_PIN: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (stb.idx == 8'(s)) rdNext = {flagQ[s], 25'b0, 6'(pinQ[s])};
      end
      RD_CORE: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (stb.idx == 8'(s) && mappedQ[s]) rdNext = 32'(1) << coreQ[s];
      end
      RD_LOCAL: begin
        for (int c = 0; c < NUM_CORE; c++)
          if (stb.idx == 8'(c)) rdNext = {locEnQ[c], 25'b0, 6'(locPinQ[c])};
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  input  logic [NUM_SRC-1:0]          srcIn,
  input  logic [NUM_CORE-1:0]         localIrq,
  output logic [NUM_CORE*NUM_PIN-1:0] irqOut
);
  strobe_t stb;

  irq_router_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .stb    (stb)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcIn    (srcIn),
    .localIrq (localIrq),
    .irqOut   (irqOut),
    .rdData   (rdData)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        rdEn,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           rdData,
  input logic [NUM_CORE*NUM_PIN-1:0] irqOut
);
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(NUM_SRC / 8 - 1), 8'(NUM_PIN), 8'(NUM_CORE)};

  AST_RESET_OUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> irqOut == '0); // R1

  AST_CFG_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(A_CFG)) |=> rdData == CFG_WORD); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11

  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= 'h300) |=> rdData == '0); // R11

  AST_CORE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= A_CORE && int'(addr) < A_CORE + NUM_SRC)
      |=> ($onehot0(rdData) && int'($countones(rdData)) <= 1)); // R7

  AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= A_PIN && int'(addr) < A_PIN + NUM_SRC)
      |=> int'(rdData[5:0]) < NUM_PIN); // R6
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdEn   (rdEn),
  .addr   (addr),
  .rdData (rdData),
  .irqOut (irqOut)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int NS = 256;
  localparam int NC = 2;
  localparam int NP = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             rdEn = 1'b0;
  logic [9:0]       addr = '0;
  logic [31:0]      wrData = '0;
  logic [31:0]      rdData;
  logic [NS-1:0]    srcIn = '0;
  logic [NC-1:0]    localIrq = '0;
  logic [NC*NP-1:0] irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2.5 clk = ~clk;

  irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn), .localIrq(localIrq),
    .irqOut(irqOut)
  );

  // monitor: compare each read against the scoreboard
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: rdData=%h expected=%h", t, rdData, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 10'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; addr = 10'(a);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chkOut(input logic [NC*NP-1:0] e, input string t);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s: irqOut=%h expected=%h", t, irqOut, e);
    end
  endtask

  function automatic logic [NC*NP-1:0] line(input int c, input int p);
    line = '0;
    line[c*NP+p] = 1'b1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkOut('0, "R1 outputs after reset");
    rd('h000, 32'h001F_0602, "R10 config word");
    rd('h105, 32'h8000_0000, "R1 pin map reset");
    rd('h205, 32'h0, "R1 core map reset");
    rd('h018, 32'h0, "R1 enable reset");
    rd('h010, 32'h0, "R1 pending reset");
    rd('h030, 32'h8000_0000, "R1 local route reset");

    // route src5 to core1 pin3
    wr('h105, 32'h8000_0003);
    wr('h205, 32'h0000_0002);
    rd('h205, 32'h2, "R7 core map one-hot read");
    // R4 set/clear enables
    wr('h020, 32'h21);
    rd('h018, 32'h21, "R4 set enable");
    wr('h028, 32'h01);
    rd('h018, 32'h20, "R4 clear enable");
    wr('h028, 32'h00);
    rd('h018, 32'h20, "R4 zero clear no effect");

    // R2 level input into pending and output
    srcIn[5] = 1'b1;
    settle();
    chkOut(line(1, 3), "R2 R8 source to core1 pin3");
    rd('h010, 32'h20, "R5 pending view word0");
    srcIn[5] = 1'b0;
    settle();
    chkOut('0, "R2 source dropped");
    rd('h010, 32'h0, "R2 pending cleared");

    // R3 trigger
    wr('h001, 32'h8000_0028);
    rd('h011, 32'h100, "R3 trigger sets src40");
    wr('h001, 32'h8000_012C);
    rd('h011, 32'h100, "R3 out-of-range trigger ignored");
    chkOut('0, "R8 unmapped source drives nothing");
    wr('h001, 32'h0000_0028);
    rd('h011, 32'h0, "R3 trigger clears src40");

    // R8 disabled pending and OR of two sources
    wr('h107, 32'h8000_0001);
    wr('h207, 32'h1);
    wr('h108, 32'h8000_0001);
    wr('h208, 32'h1);
    wr('h001, 32'h8000_0007);
    settle();
    chkOut('0, "R8 disabled pending source");
    rd('h010, 32'h80, "R5 disabled source still pending");
    wr('h020, 32'h180);
    settle();
    chkOut(line(0, 1), "R8 enable releases pending");
    wr('h001, 32'h8000_0008);
    wr('h001, 32'h0000_0007);
    settle();
    chkOut(line(0, 1), "R8 second source holds line");
    wr('h001, 32'h0000_0008);
    settle();
    chkOut('0, "R8 both sources dropped");

    // R7 core map corner cases
    wr('h209, 32'h6);
    rd('h209, 32'h2, "R7 lowest set bit kept");
    wr('h209, 32'h4);
    rd('h209, 32'h2, "R7 core index out of range rejected");
    wr('h209, 32'h0);
    rd('h209, 32'h0, "R7 zero unmaps");

    // R6 pin map
    wr('h109, 32'h8000_0006);
    rd('h109, 32'h8000_0000, "R6 out-of-range pin discarded");
    wr('h109, 32'h0000_0002);
    rd('h109, 32'h2, "R6 pin and flag stored");

    // R9 local input
    localIrq[0] = 1'b1;
    settle();
    chkOut(line(0, 0), "R9 local onto pin0");
    wr('h030, 32'h8000_0004);
    settle();
    chkOut(line(0, 4), "R9 local moved to pin4");
    wr('h030, 32'h0000_0004);
    settle();
    chkOut('0, "R9 local route disabled");
    wr('h030, 32'h8000_0007);
    rd('h030, 32'h4, "R9 bad local pin discarded");
    localIrq[0] = 1'b0;

    // R11 unimplemented space
    wr('h300, 32'hFFFF_FFFF);
    wr('h005, 32'hFFFF_FFFF);
    rd('h300, 32'h0, "R11 unimplemented read zero");
    rd('h018, 32'h1A0, "R11 stray writes leave enables");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d reads unanswered, expected 0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule